// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block tracks the position of one incremental encoder. The two phase inputs and the index input are first synchronised and then debounced on a programmable filter clock. The filtered phases are decoded into single up or down count steps, which drive a 24-bit position counter. The decoder can run in one of four schemes: one count per full phase cycle, one per edge of A, one per edge of A or B, or a plain count-and-direction scheme. In the plain scheme, A carries the count pulses and B sets the direction.

The counter has three count modes. The first wraps freely. The second stops at the first overflow or underflow. The third wraps within the range 0..P, where P is a preset value. The preset value also acts as a compare target and as the value loaded into the counter. Carry, borrow and match events appear as one-cycle pulses. Each of these events also flips a bit in a status byte. The status byte also holds a sign bit, the last direction counted and a frozen bit.

The index input can be set up to clear the counter, load it from the preset, or copy it into a holding latch. The index passes through the same filter and decode pipeline as the phases, so it acts in step with them. A host writes registers and commands through a byte-wide write strobe. It reads the counter, the latch and the status byte on dedicated output ports.

Top module: `qpos_counter`

## Requirements
- R1: After reset the count, the latch and the status byte are all zero. The decode scheme is edge-of-A-or-B, the count mode is free wrap and the index does nothing.
- R2: In the edge-of-A-or-B scheme (mode byte bits [1:0]=3), each phase edge makes one step. The sequence AB = 00,10,11,01,00 counts up and its reverse counts down.
- R3: In the edge-of-A scheme (bits [1:0]=2), only edges of A make steps. A full forward phase cycle adds 2.
- R4: In the once-per-cycle scheme (bits [1:0]=1), a rise of A while B=0 counts up and a fall of A while B=0 counts down. A full forward cycle adds 1 and a full reverse cycle subtracts 1.
- R5: In the count-and-direction scheme (bits [1:0]=0), each rising edge of A makes one step: up when B=0 and down when B=1.
- R6: In free-wrap mode (mode byte bits [3:2]=0), stepping up from 0xFFFFFF gives 0 with a carry pulse. Stepping down from 0 gives 0xFFFFFF with a borrow pulse. The two pulses are never high together.
- R7: The status byte is {2'b00, frozen, dir, sign, match-toggle, carry-toggle, borrow-toggle} from bit 7 down to bit 0. A borrow flips bit 0 and sets sign. A carry flips bit 1 and clears sign. Dir holds 1 when the last applied step was up.
- R8: In non-recycle mode (bits [3:2]=1), an overflow or underflow wraps the counter once and then freezes it. While frozen, steps are ignored. A clear or a load unfreezes it.
- R9: In modulo mode (bits [3:2]=2), stepping up from P gives 0 with a carry. Stepping down from 0 gives P with a borrow.
- R10: Whenever an applied step leaves the counter equal to P, a match pulse is issued and status bit 2 flips.
- R11: The write addresses are 0,1,2 for the P bytes (low to high), 3 for the mode byte, 4 for the index function and 5 for commands. Command codes: 1 clears the count, 2 loads the count from P, 3 copies the count into the latch, 4 loads the filter divider from P[7:0], 5 clears status bits 0 to 3.
- R12: Index function codes written to address 4: 0 does nothing, 1 clears the count, 2 loads P and 3 copies the count into the latch. The function is applied on each rising edge of the filtered index.
- R13: The filter clock period is (divider+1) system clocks. A phase or index level is accepted only after three consecutive equal filter-clock samples, so a larger divider delays each count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A (count input in count-and-direction scheme) |
| enc_b | input | 1 | Encoder phase B (direction in count-and-direction scheme) |
| enc_idx | input | 1 | Encoder index, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| count_q | output | 24 | Current position count |
| latch_q | output | 24 | Holding latch |
| status_q | output | 8 | Status byte |
| carry_p | output | 1 | Carry event pulse |
| borrow_p | output | 1 | Borrow event pulse |
| match_p | output | 1 | Count-equals-preset pulse |

## Verification
The same full forward and reverse phase cycles are played in each of the three quadrature schemes. The resulting counts of 4, 2 and 1 per cycle separate the schemes, and the return to zero on reversal confirms the direction rule. Single pulses in the count-and-direction scheme drive the counter across 0/0xFFFFFF and across the preset in each count mode, which separates wrap, freeze and modulo behaviour. The status byte is checked after every crossing. Index pulses are given under each index function, and a larger filter divider is shown to hold back a count that the fastest setting would already have registered.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

    typedef enum logic [1:0] {
        QD_DIR = 2'd0,
        QD_X1  = 2'd1,
        QD_X2  = 2'd2,
        QD_X4  = 2'd3
    } qdec_e;

    typedef enum logic [1:0] {
        CM_WRAP  = 2'd0,
        CM_HOLD  = 2'd1,
        CM_MODN  = 2'd2,
        CM_SPARE = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        IX_NONE  = 2'd0,
        IX_CLEAR = 2'd1,
        IX_LOAD  = 2'd2,
        IX_LATCH = 2'd3
    } ixfn_e;

    localparam logic [7:0] OP_CLEAR = 8'h01;
    localparam logic [7:0] OP_LOAD  = 8'h02;
    localparam logic [7:0] OP_LATCH = 8'h03;
    localparam logic [7:0] OP_PSC   = 8'h04;
    localparam logic [7:0] OP_FLAGS = 8'h05;

    typedef struct packed {
        cmode_e cm;
        qdec_e  qd;
    } mode_t;

    typedef struct packed {
        logic step;
        logic up;
    } step_t;

    typedef struct packed {
        logic carry;
        logic borrow;
        logic match;
    } evt_t;

    typedef struct packed {
        logic [1:0] spare;
        logic       frozen;
        logic       dir;
        logic       sign;
        logic       mt;
        logic       ct;
        logic       bt;
    } status_t;

    // a0/b0: previous filtered levels, a1/b1: current filtered levels
    function automatic step_t decode_step(qdec_e qd, logic a0, logic b0,
                                          logic a1, logic b1);
        step_t r;
        logic  ea;
        logic  eb;
        logic  fwd;
        ea  = a0 ^ a1;
        eb  = b0 ^ b1;
        fwd = a1 ^ b0;
        case (qd)
            QD_X4: begin
                r.step = ea ^ eb;
                r.up   = fwd;
            end
            QD_X2: begin
                r.step = ea & ~eb;
                r.up   = fwd;
            end
            QD_X1: begin
                r.step = ea & ~eb & ~b1;
                r.up   = a1;
            end
            default: begin
                r.step = ea & a1;
                r.up   = ~b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qpos_prescale.sv
module qpos_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PSC_W-1:0] load_val,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;
    logic [PSC_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= load_val;
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= div_q;
        end else begin
            cnt_q <= cnt_q - PSC_W'(1);
        end
    end
endmodule

// File: rtl/qpos_filter.sv
module qpos_filter #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic dout
);
    logic [1:0]      sync_q;
    logic [TAPS-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            dout   <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (tick) begin
                hist_q <= {hist_q[TAPS-2:0], sync_q[1]};
            end
            if (&hist_q) begin
                dout <= 1'b1;
            end else if (~|hist_q) begin
                dout <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
    import qpos_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  qdec_e qd,
    input  logic  a_f,
    input  logic  b_f,
    input  logic  ix_f,
    output step_t step_o,
    output logic  ix_rise_o
);
    logic a_p;
    logic b_p;
    logic ix_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_p  <= 1'b0;
            b_p  <= 1'b0;
            ix_p <= 1'b0;
        end else begin
            a_p  <= a_f;
            b_p  <= b_f;
            ix_p <= ix_f;
        end
    end

    assign step_o    = decode_step(qd, a_p, b_p, a_f, b_f);
    assign ix_rise_o = ix_f & ~ix_p;
endmodule

// File: rtl/qpos_core.sv
module qpos_core
    import qpos_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 3,
    parameter int PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  step_t             step_i,
    input  logic              ix_rise_i,
    output qdec_e             qd_o,
    output logic              psc_ld_o,
    output logic [PSC_W-1:0]  psc_val_o,
    output logic [CNT_W-1:0]  pr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  ol_o,
    output status_t           status_o,
    output evt_t              evt_o
);
    localparam int NB      = (CNT_W + 7) / 8;
    localparam int PRW     = NB * 8;
    localparam int A_MODE  = NB;
    localparam int A_INDEX = NB + 1;
    localparam int A_OP    = NB + 2;
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [PRW-1:0]   pr_bytes;
    logic [CNT_W-1:0] pr;
    mode_t            mode_q;
    ixfn_e            ix_q;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] ol_q, ol_n;
    status_t          st_q, st_n;
    evt_t             ev;
    logic             op_hit;

    for (genvar g = 0; g < NB; g++) begin : g_pr
        always_ff @(posedge clk) begin
            if (rst) begin
                pr_bytes[g*8 +: 8] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                pr_bytes[g*8 +: 8] <= wr_data;
            end
        end
    end

    assign pr = pr_bytes[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{cm: CM_WRAP, qd: QD_X4};
            ix_q   <= IX_NONE;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_MODE)) begin
                mode_q <= mode_t'(wr_data[3:0]);
            end
            if (wr_addr == ADDR_W'(A_INDEX)) begin
                ix_q <= ixfn_e'(wr_data[1:0]);
            end
        end
    end

    assign op_hit    = wr_en && (wr_addr == ADDR_W'(A_OP));
    assign psc_ld_o  = op_hit && (wr_data == OP_PSC);
    assign psc_val_o = pr[PSC_W-1:0];
    assign qd_o      = mode_q.qd;

    always_comb begin
        cnt_n = cnt_q;
        ol_n  = ol_q;
        st_n  = st_q;
        ev    = '0;
        if (op_hit && wr_data == OP_CLEAR) begin
            cnt_n       = '0;
            st_n.frozen = 1'b0;
        end else if (op_hit && wr_data == OP_LOAD) begin
            cnt_n       = pr;
            st_n.frozen = 1'b0;
        end else if (ix_rise_i && ix_q == IX_CLEAR) begin
            cnt_n       = '0;
            st_n.frozen = 1'b0;
        end else if (ix_rise_i && ix_q == IX_LOAD) begin
            cnt_n       = pr;
            st_n.frozen = 1'b0;
        end else if (step_i.step && !st_q.frozen) begin
            st_n.dir = step_i.up;
            if (step_i.up) begin
                if (cnt_q == MAXV || (mode_q.cm == CM_MODN && cnt_q == pr)) begin
                    cnt_n       = '0;
                    ev.carry    = 1'b1;
                    st_n.frozen = (mode_q.cm == CM_HOLD);
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end else begin
                if (cnt_q == '0) begin
                    cnt_n       = (mode_q.cm == CM_MODN) ? pr : MAXV;
                    ev.borrow   = 1'b1;
                    st_n.frozen = (mode_q.cm == CM_HOLD);
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            ev.match = (cnt_n == pr);
        end

        if (op_hit && wr_data == OP_LATCH) begin
            ol_n = cnt_q;
        end else if (ix_rise_i && ix_q == IX_LATCH) begin
            ol_n = cnt_q;
        end

        if (ev.borrow) begin
            st_n.bt   = ~st_q.bt;
            st_n.sign = 1'b1;
        end
        if (ev.carry) begin
            st_n.ct   = ~st_q.ct;
            st_n.sign = 1'b0;
        end
        if (ev.match) begin
            st_n.mt = ~st_q.mt;
        end
        if (op_hit && wr_data == OP_FLAGS) begin
            st_n.bt   = 1'b0;
            st_n.ct   = 1'b0;
            st_n.mt   = 1'b0;
            st_n.sign = 1'b0;
        end
        st_n.spare = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ol_q  <= '0;
            st_q  <= '0;
            evt_o <= '0;
        end else begin
            cnt_q <= cnt_n;
            ol_q  <= ol_n;
            st_q  <= st_n;
            evt_o <= ev;
        end
    end

    assign pr_o     = pr;
    assign cnt_o    = cnt_q;
    assign ol_o     = ol_q;
    assign status_o = st_q;
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
    import qpos_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 3,
    parameter int PSC_W  = 8,
    parameter int TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_idx,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  latch_q,
    output logic [7:0]        status_q,
    output logic              carry_p,
    output logic              borrow_p,
    output logic              match_p
);
    localparam int NIN = 3;

    logic             ftick;
    logic             psc_ld;
    logic [PSC_W-1:0] psc_val;
    logic [NIN-1:0]   raw_in;
    logic [NIN-1:0]   filt;
    qdec_e            qd;
    step_t            step;
    logic             ix_rise;
    logic [CNT_W-1:0] pr_val;
    status_t          st;
    evt_t             evt;

    assign raw_in = {enc_idx, enc_b, enc_a};

    qpos_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst      (rst),
        .load     (psc_ld),
        .load_val (psc_val),
        .tick     (ftick)
    );

    for (genvar i = 0; i < NIN; i++) begin : g_filt
        qpos_filter #(.TAPS(TAPS)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .tick (ftick),
            .din  (raw_in[i]),
            .dout (filt[i])
        );
    end

    qpos_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .qd        (qd),
        .a_f       (filt[0]),
        .b_f       (filt[1]),
        .ix_f      (filt[2]),
        .step_o    (step),
        .ix_rise_o (ix_rise)
    );

    qpos_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .step_i    (step),
        .ix_rise_i (ix_rise),
        .qd_o      (qd),
        .psc_ld_o  (psc_ld),
        .psc_val_o (psc_val),
        .pr_o      (pr_val),
        .cnt_o     (count_q),
        .ol_o      (latch_q),
        .status_o  (st),
        .evt_o     (evt)
    );

    assign status_q = st;
    assign carry_p  = evt.carry;
    assign borrow_p = evt.borrow;
    assign match_p  = evt.match;
endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pr,
    input logic [7:0]       status,
    input logic             carry,
    input logic             borrow,
    input logic             match
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    assert_carry_borrow_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(carry && borrow));

    assert_carry_lands_zero_R6: assert property (@(posedge clk) disable iff (rst)
        carry |-> cnt == '0);

    // R9: a borrow lands on the top value or on the preset
    assert_borrow_target_R9: assert property (@(posedge clk) disable iff (rst)
        borrow |-> (cnt == MAXV || cnt == $past(pr)));

    assert_borrow_toggles_R7: assert property (@(posedge clk) disable iff (rst)
        (borrow && !$past(wr_en)) |-> (status[0] != $past(status[0]) && status[3]));

    assert_frozen_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (status[5] && $past(status[5])) |-> cnt == $past(cnt));

    assert_match_equal_R10: assert property (@(posedge clk) disable iff (rst)
        match |-> cnt == $past(pr));
endmodule

bind qpos_counter qpos_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .cnt    (count_q),
    .pr     (pr_val),
    .status (status_q),
    .carry  (carry_p),
    .borrow (borrow_p),
    .match  (match_p)
);

// File: tb/qpos_counter_bench.sv
module qpos_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic        enc_idx = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [23:0] count_q;
    logic [23:0] latch_q;
    logic [7:0]  status_q;
    logic        carry_p;
    logic        borrow_p;
    logic        match_p;

    int total = 0;
    int bad = 0;
    int ph = 0;

    always #4 clk = ~clk;

    qpos_counter u_qpos_counter (
        .clk      (clk),
        .rst      (rst),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .enc_idx  (enc_idx),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .count_q  (count_q),
        .latch_q  (latch_q),
        .status_q (status_q),
        .carry_p  (carry_p),
        .borrow_p (borrow_p),
        .match_p  (match_p)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n = 12);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pr(input logic [23:0] v);
        wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, v[23:16]);
    endtask

    // one phase step; phase order AB = 00,10,11,01 is forward
    task automatic qstep(input logic up);
        ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
        case (ph)
            0: begin enc_a = 1'b0; enc_b = 1'b0; end
            1: begin enc_a = 1'b1; enc_b = 1'b0; end
            2: begin enc_a = 1'b1; enc_b = 1'b1; end
            default: begin enc_a = 1'b0; enc_b = 1'b1; end
        endcase
        settle();
    endtask

    task automatic pulse(input logic up);
        enc_b = ~up;
        settle(2);
        enc_a = 1'b1; settle();
        enc_a = 1'b0; settle();
        enc_b = 1'b0; settle(2);
    endtask

    task automatic ipulse();
        enc_idx = 1'b1; settle();
        enc_idx = 1'b0; settle();
    endtask

    task automatic t_reset();
        chk("R1 count", 32'(count_q), 32'h0);
        chk("R1 latch", 32'(latch_q), 32'h0);
        chk("R1 status", 32'(status_q), 32'h0);
    endtask

    task automatic t_x4();
        set_pr(24'h123456);
        wr(3'd5, 8'h01);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        chk("R2 x4 forward", 32'(count_q), 32'd4);
        for (int i = 0; i < 4; i++) qstep(1'b0);
        chk("R2 x4 reverse", 32'(count_q), 32'd0);
    endtask

    task automatic t_x2();
        wr(3'd3, 8'h02);
        wr(3'd5, 8'h01);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        chk("R3 x2 forward", 32'(count_q), 32'd2);
        for (int i = 0; i < 4; i++) qstep(1'b0);
        chk("R3 x2 reverse", 32'(count_q), 32'd0);
    endtask

    task automatic t_x1();
        wr(3'd3, 8'h01);
        wr(3'd5, 8'h01);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        chk("R4 x1 forward", 32'(count_q), 32'd1);
        for (int i = 0; i < 4; i++) qstep(1'b0);
        chk("R4 x1 reverse", 32'(count_q), 32'd0);
    endtask

    task automatic t_dir();
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h01);
        for (int i = 0; i < 3; i++) pulse(1'b1);
        chk("R5 dir up", 32'(count_q), 32'd3);
        pulse(1'b0);
        chk("R5 dir down", 32'(count_q), 32'd2);
    endtask

    task automatic t_wrap();
        wr(3'd5, 8'h01);
        wr(3'd5, 8'h05);
        pulse(1'b0);
        chk("R6 underflow value", 32'(count_q), 32'hFFFFFF);
        chk("R7 status after borrow", 32'(status_q), 32'h09);
        pulse(1'b1);
        chk("R6 overflow value", 32'(count_q), 32'h0);
        chk("R7 status after carry", 32'(status_q), 32'h13);
    endtask

    task automatic t_hold();
        wr(3'd3, 8'h04);
        wr(3'd5, 8'h01);
        wr(3'd5, 8'h05);
        pulse(1'b0);
        chk("R8 wrap before freeze", 32'(count_q), 32'hFFFFFF);
        chk("R8 status frozen", 32'(status_q), 32'h29);
        pulse(1'b1);
        pulse(1'b1);
        chk("R8 steps ignored", 32'(count_q), 32'hFFFFFF);
        chk("R8 status unchanged", 32'(status_q), 32'h29);
        wr(3'd5, 8'h02);
        settle(2);
        chk("R8 load unfreezes", 32'(status_q), 32'h09);
        pulse(1'b1);
        chk("R8 counts again", 32'(count_q), 32'h123457);
    endtask

    task automatic t_modn();
        wr(3'd3, 8'h08);
        set_pr(24'd5);
        wr(3'd5, 8'h01);
        wr(3'd5, 8'h05);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        chk("R10 reach preset", 32'(count_q), 32'd5);
        chk("R10 match toggle", 32'(status_q), 32'h14);
        pulse(1'b1);
        chk("R9 up past preset", 32'(count_q), 32'd0);
        chk("R9 status carry", 32'(status_q), 32'h16);
        pulse(1'b0);
        chk("R9 down from zero", 32'(count_q), 32'd5);
        chk("R9 status borrow", 32'(status_q), 32'h0B);
    endtask

    task automatic t_cmds();
        wr(3'd3, 8'h00);
        set_pr(24'h000010);
        wr(3'd5, 8'h02);
        settle(2);
        chk("R11 load command", 32'(count_q), 32'h10);
        wr(3'd5, 8'h03);
        wr(3'd5, 8'h01);
        settle(2);
        chk("R11 latch command", 32'(latch_q), 32'h10);
        chk("R11 clear command", 32'(count_q), 32'h0);
        wr(3'd5, 8'h05);
        settle(2);
        chk("R11 flag clear", 32'(status_q), 32'h00);
    endtask

    task automatic t_index();
        set_pr(24'h000777);
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h02);
        pulse(1'b1);
        chk("R12 before index", 32'(count_q), 32'h778);
        ipulse();
        chk("R12 index clears", 32'(count_q), 32'h0);
        wr(3'd4, 8'h02);
        ipulse();
        chk("R12 index loads", 32'(count_q), 32'h777);
        wr(3'd4, 8'h03);
        pulse(1'b1);
        ipulse();
        chk("R12 index latches", 32'(latch_q), 32'h778);
        chk("R12 latch keeps count", 32'(count_q), 32'h778);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h01);
        ipulse();
        chk("R12 index off count", 32'(count_q), 32'h0);
        chk("R12 index off latch", 32'(latch_q), 32'h778);
    endtask

    task automatic t_prescale();
        set_pr(24'd3);
        wr(3'd5, 8'h04);
        wr(3'd5, 8'h01);
        enc_b = 1'b0;
        settle(4);
        enc_a = 1'b1;
        settle(10);
        chk("R13 slow filter not yet", 32'(count_q), 32'd0);
        settle(40);
        chk("R13 slow filter counted", 32'(count_q), 32'd1);
        enc_a = 1'b0;
        settle(48);
        set_pr(24'd0);
        wr(3'd5, 8'h04);
        settle(4);
        enc_a = 1'b1;
        settle(10);
        chk("R13 fast filter counted", 32'(count_q), 32'd2);
        enc_a = 1'b0;
        settle();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle(2);
        t_reset();
        t_x4();
        t_x2();
        t_x1();
        t_dir();
        t_wrap();
        t_hold();
        t_modn();
        t_cmds();
        t_index();
        t_prescale();
        summary();
        $finish;
    end
endmodule